// File: doc/BRIEF.md
# Overlapped Polyphase Input Commutator

This block is the front end of a polyphase channelizer whose channels overlap by half their width. It takes a serial stream of complex samples, one 32-bit word per accepted cycle, and turns it into parallel frames of D branch words. D is the channel count: an even parameter of at least 4, with a default of 32. Call the hop H = D/2.

A new frame is emitted after every H accepted samples, so the stream is decimated by H rather than by D. Branches 0 to H-1 hold the hop that has just completed, in reversed arrival order. Branches H to D-1 repeat what branches 0 to H-1 held one frame earlier. Every input sample therefore reaches two consecutive frames.

Each frame comes with a one-cycle valid pulse. The frame holds its value until the next pulse, which lets a downstream filter bank sample it on the pulse. An input qualifier marks the cycles that carry a sample, so idle cycles in the stream never shift the hop boundaries.

Top module: `overlap_commutator`

## Requirements
- R1: The input word carries the signed I sample in bits 15:0 and the signed Q sample in bits 31:16. Output branch b sits in bits [32*b +: 32] of the frame bus with the same I/Q packing.
- R2: `frame_valid` goes high for exactly one cycle, in the cycle after the edge that accepts the H-th sample of a hop. It is low in every other cycle.
- R3: When a frame is issued, branch i (0 <= i < H) holds the sample with arrival position H-1-i within the completed hop. Position 0 is the first sample of the hop, so branch 0 holds the newest sample.
- R4: When a frame is issued, branch H+i holds the value that branch i held in the previous frame.
- R5: In the first frame after reset, branches H to D-1 are zero.
- R6: A cycle with `in_valid` low shifts nothing and does not advance the hop position. Frames formed from a gapped stream equal those formed from the same samples sent without gaps.
- R7: While `rst_n` is low at a clock edge, the frame bus clears to zero and `frame_valid` drops low. The hop position and the delayed half-frame also clear.
- R8: Between valid pulses the frame bus keeps its value.
- R9: Samples accepted before a reset never appear in any frame after the reset. The first frame after reset is built only from the first H samples accepted after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | High in cycles where `in_iq` carries a sample |
| in_iq | input | 32 | Input sample: I in bits 15:0, Q in bits 31:16 |
| frame_valid | output | 1 | One-cycle pulse marking a new frame |
| frame_iq | output | 32*D | Parallel frame: branch b in bits [32*b +: 32] |

## Verification
The first directed pattern is a counting ramp whose I and Q fields differ. With it, a reversed branch order, swapped I/Q halves or an off-by-one hop boundary each give a distinct wrong value. A half hop followed by a long idle gap checks that idle cycles neither shift the data nor count toward the hop. A reset in the middle of a hop shows whether stale samples or a stale delayed half leak into the next frame. Long runs of random data with a random qualifier then compare every frame against a reference that rebuilds the frames from the accepted samples alone, and check the hold behaviour between pulses.

// File: rtl/ovc_pkg.sv
// Package ovc_pkg
// Holds the shared word layout of the overlapped commutator.
// Assumes one complex sample per 32-bit word, with I in the low half.
package ovc_pkg;
    localparam int SAMPLE_W = 16;
    localparam int WORD_W   = 2 * SAMPLE_W;

    // One complex sample; Q is declared first so that it lands in the high half.
    typedef struct packed {
        logic signed [SAMPLE_W-1:0] q;
        logic signed [SAMPLE_W-1:0] i;
    } iq_word_t;
endpackage

// File: rtl/ovc_hop_counter.sv
// Module ovc_hop_counter
// Counts the accepted samples of the current hop, modulo HOP.
// Raises wrap in the same cycle as the sample that completes the hop.
// Assumes HOP >= 2 and that adv is high only for accepted samples.
module ovc_hop_counter #(
    parameter int HOP = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       adv,
    output logic [$clog2(HOP)-1:0]     cnt,
    output logic                       wrap
);
    localparam int CNT_W = $clog2(HOP);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOP - 1);

    // wrap marks the accepted sample that closes the hop.
    always_comb begin
        wrap = adv && (cnt == LAST);
    end

    // Advance on accepted samples and return to zero after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: the count stays within one hop.
    a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R2: a completed hop starts the next one at position zero.
    a_r2_wrap_restart: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));

    // R6: an idle cycle leaves the hop position alone.
    a_r6_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(cnt));
endmodule

// File: rtl/ovc_half_shifter.sv
// Module ovc_half_shifter
// Keeps the HOP most recent accepted samples, with slot 0 the newest.
// next_half gives the slot contents as they will be after the current
// cycle's shift. The frame register can then capture the hop together
// with the sample that completes it.
// Assumes HOP >= 2.
module ovc_half_shifter
    import ovc_pkg::*;
#(
    parameter int HOP = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      adv,
    input  iq_word_t                  din,
    output logic [HOP*WORD_W-1:0]     next_half
);
    localparam int HALF_W = HOP * WORD_W;

    logic [HALF_W-1:0] slots;

    // Slot 0 takes the incoming sample; each older slot takes its younger neighbour.
    always_comb begin
        next_half[0 +: WORD_W] = adv ? din : slots[0 +: WORD_W];
    end

    for (genvar k = 1; k < HOP; k++) begin : g_slot
        // Move one place toward the older end when a sample is accepted.
        always_comb begin
            next_half[k*WORD_W +: WORD_W] = adv ? slots[(k-1)*WORD_W +: WORD_W]
                                                : slots[k*WORD_W +: WORD_W];
        end
    end

    // Register the shifted contents; reset empties every slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots <= '0;
        end else begin
            slots <= next_half;
        end
    end

    // R6: an idle cycle leaves the stored samples untouched.
    a_r6_no_shift_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(slots));

    // R3: an accepted sample becomes the newest slot.
    a_r3_newest_in_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (slots[0 +: WORD_W] == $past(din)));

    // R3: the sample that was newest moves to the next slot.
    a_r3_age_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (slots[WORD_W +: WORD_W] == $past(slots[0 +: WORD_W])));
endmodule

// File: rtl/ovc_frame_register.sv
// Module ovc_frame_register
// Holds the output frame. On load, the lower half takes the completed hop
// and the upper half takes the previous lower half, which gives the
// one-frame delay. valid follows load by one cycle.
// Assumes load is high at most once per hop.
module ovc_frame_register
    import ovc_pkg::*;
#(
    parameter int HOP = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [HOP*WORD_W-1:0]       new_half,
    output logic [2*HOP*WORD_W-1:0]     frame,
    output logic                        valid
);
    localparam int HALF_W = HOP * WORD_W;

    logic [HALF_W-1:0] lower_q;
    logic [HALF_W-1:0] upper_q;

    // Capture a new hop and push the old one into the delayed half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lower_q <= '0;
            upper_q <= '0;
        end else if (load) begin
            lower_q <= new_half;
            upper_q <= lower_q;
        end
    end

    // Pulse valid for the cycle after each load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else begin
            valid <= load;
        end
    end

    // Place the current hop on the low branches and the delayed one above it.
    always_comb begin
        frame = {upper_q, lower_q};
    end

    // R4: the delayed half repeats the previous current half.
    a_r4_delay_line: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (frame[HALF_W +: HALF_W] == $past(frame[0 +: HALF_W])));

    // R8: without a load the frame holds.
    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(frame));
endmodule

// File: rtl/overlap_commutator.sv
// Module overlap_commutator
// Top of the overlapped polyphase input commutator. Builds D-branch frames
// that advance by D/2 accepted samples. Branches 0..D/2-1 hold the newest
// hop in reversed arrival order; branches D/2..D-1 hold the hop before it.
// Assumes D is even and at least 4. Reset is synchronous and active low.
module overlap_commutator
    import ovc_pkg::*;
#(
    parameter int D = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [31:0]           in_iq,
    output logic                  frame_valid,
    output logic [32*D-1:0]       frame_iq
);
    localparam int HOP   = D / 2;
    localparam int CNT_W = $clog2(HOP);

    iq_word_t                 sample;
    logic [CNT_W-1:0]         hop_pos;
    logic                     hop_done;
    logic [HOP*WORD_W-1:0]    shifted_half;

    // Read the input word with its I/Q layout.
    always_comb begin
        sample = iq_word_t'(in_iq);
    end

    ovc_hop_counter #(
        .HOP (HOP)
    ) u_hop_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_valid),
        .cnt   (hop_pos),
        .wrap  (hop_done)
    );

    ovc_half_shifter #(
        .HOP (HOP)
    ) u_half_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (in_valid),
        .din       (sample),
        .next_half (shifted_half)
    );

    ovc_frame_register #(
        .HOP (HOP)
    ) u_frame_register (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hop_done),
        .new_half (shifted_half),
        .frame    (frame_iq),
        .valid    (frame_valid)
    );

    // R2: a frame pulse lasts a single cycle.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    // R6: no frame follows an idle cycle.
    a_r6_gap_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !frame_valid);

    // R3: branch 0 of a new frame is the sample that completed the hop.
    a_r3_branch0_newest: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hop_done) |=> (frame_iq[31:0] == $past(in_iq)));
endmodule

// File: tb/overlap_commutator_bench.sv
module overlap_commutator_bench;
    localparam int D = 32;
    localparam int H = D / 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [31:0]       in_iq = '0;
    logic              frame_valid;
    logic [32*D-1:0]   frame_iq;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Reference model state.
    logic [31:0] hop_buf [H];
    logic [31:0] exp_br  [D];
    int          exp_cnt = 0;
    logic        exp_valid = 0;
    bit          fresh = 0;   // no frame issued since the last reset

    overlap_commutator #(.D(D)) u_overlap_commutator (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_iq       (in_iq),
        .frame_valid (frame_valid),
        .frame_iq    (frame_iq)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] pack_iq(input logic [15:0] i_s, input logic [15:0] q_s);
        return {q_s, i_s};
    endfunction

    function automatic logic [32*D-1:0] exp_bus();
        logic [32*D-1:0] b;
        for (int k = 0; k < D; k++) b[32*k +: 32] = exp_br[k];
        return b;
    endfunction

    task automatic fail_msg(input string req, input logic [32*D-1:0] act, input logic [32*D-1:0] exp);
        fails++;
        $display("FAIL %s actual=%h expected=%h", req, act, exp);
    endtask

    // Reference update for one clock edge.
    task automatic model_edge(input logic v, input logic [31:0] d, input logic r_n);
        if (!r_n) begin
            exp_cnt = 0; exp_valid = 0; fresh = 1;
            for (int k = 0; k < D; k++) exp_br[k] = '0;
            for (int k = 0; k < H; k++) hop_buf[k] = '0;
        end else begin
            exp_valid = 0;
            if (v) begin
                hop_buf[exp_cnt] = d;
                exp_cnt++;
                if (exp_cnt == H) begin
                    for (int k = 0; k < H; k++) exp_br[H+k] = exp_br[k];
                    for (int k = 0; k < H; k++) exp_br[k] = hop_buf[H-1-k];
                    exp_cnt = 0;
                    exp_valid = 1;
                end
            end
        end
    endtask

    // Drive one cycle, update the model at the edge, check at the falling edge.
    task automatic step(input logic v, input logic [31:0] d, input logic r_n);
        string tag;
        in_valid = v; in_iq = d; rst_n = r_n;
        @(posedge clk);
        model_edge(v, d, r_n);
        @(negedge clk);
        checks++;
        tag = !r_n ? "R7 valid" : "R2/R6 valid";
        if (frame_valid !== exp_valid)
            fail_msg(tag, {{(32*D-1){1'b0}}, frame_valid}, {{(32*D-1){1'b0}}, exp_valid});
        checks++;
        tag = !r_n ? "R7 frame" : (exp_valid ? "R3/R4 frame" : "R8 hold");
        if (frame_iq !== exp_bus()) fail_msg(tag, frame_iq, exp_bus());
        if (exp_valid && fresh) begin
            checks++;   // R5: delayed half empty in first frame after reset
            if (frame_iq[32*D-1:32*H] !== '0)
                fail_msg("R5 upper zero", {{(32*H){1'b0}}, frame_iq[32*D-1:32*H]}, '0);
            fresh = 0;
        end
    endtask

    initial begin
        int unused;
        logic [31:0] last;
        unused = $urandom(32'h5EED_0C01);
        for (int k = 0; k < D; k++) exp_br[k] = '0;

        // R7: reset state.
        repeat (3) step(1'b0, '0, 1'b0);

        // R1/R3/R4/R5: counting ramp, I and Q fields distinct.
        for (int n = 0; n < 3*H; n++)
            step(1'b1, pack_iq(16'(n + 1), 16'(16'h8000 | n)), 1'b1);
        checks++;   // R1: field placement of branch 0 (newest) and branch H-1 (oldest)
        if (frame_iq[15:0] !== 16'(3*H) || frame_iq[31:16] !== 16'(16'h8000 | (3*H-1)))
            fail_msg("R1 branch0 fields", {{(32*D-32){1'b0}}, frame_iq[31:0]},
                     {{(32*D-32){1'b0}}, pack_iq(16'(3*H), 16'(16'h8000 | (3*H-1)))});
        checks++;
        if (frame_iq[32*(H-1) +: 16] !== 16'(2*H + 1))
            fail_msg("R1 branch H-1 I field", {{(32*D-16){1'b0}}, frame_iq[32*(H-1) +: 16]},
                     {{(32*D-16){1'b0}}, 16'(2*H + 1)});

        // R6: half hop, long idle gap, then the rest.
        for (int n = 0; n < H/2; n++) step(1'b1, $urandom, 1'b1);
        repeat (20) step(1'b0, $urandom, 1'b1);
        for (int n = 0; n < H - H/2; n++) step(1'b1, $urandom, 1'b1);

        // Random stream with a random qualifier.
        for (int n = 0; n < 3000; n++) step(($urandom % 10) < 7, $urandom, 1'b1);

        // R9: partial hop, reset, then a fresh hop.
        for (int n = 0; n < 5; n++) step(1'b1, 32'hDEAD_0000 | n, 1'b1);
        repeat (2) step(1'b1, 32'hBAD0_BAD0, 1'b0);
        last = '0;
        for (int n = 0; n < H; n++) begin
            last = pack_iq(16'(16'h0100 + n), 16'(16'h0200 + n));
            step(1'b1, last, 1'b1);
        end
        checks++;   // R9: only post-reset samples in the frame
        if (frame_iq[31:0] !== last || frame_iq[32*(H-1) +: 32] !== pack_iq(16'h0100, 16'h0200))
            fail_msg("R9 post-reset frame", frame_iq, exp_bus());

        // More random traffic, including full-rate bursts.
        for (int n = 0; n < 1500; n++) step(($urandom % 4) != 0, $urandom, 1'b1);
        for (int n = 0; n < 4*H; n++) step(1'b1, $urandom, 1'b1);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule